// File: doc/BRIEF.md
# E1 Timeslot-0 Spare Bit Access

This block sits between an E1 framer and a host and gives the host access to the international bit and the five national spare bits carried in timeslot 0. On the receive side it watches each timeslot-0 byte the framer delivers, tagged with whether it came from an alignment frame or a non-alignment frame. It holds the alignment byte until the non-alignment byte that follows it arrives, then updates both host-visible words in one step and signals the host. The host then has two frames to read them before the next pair replaces them.

On the transmit side the framer asks for a timeslot-0 byte once per frame. At each alignment-frame request the block samples the host's two transmit words and signals the host. It then builds the outgoing byte: the alignment pattern is forced, and in non-alignment frames the fixed one bit is forced. Separate controls can take over the international bit or any single spare bit from external serial data, and these overrides quietly replace whatever the host wrote. Each host event is a one-cycle pulse and also a sticky flag that the host clears with an acknowledge.

Top module: `e1s_ts0_access`

## Requirements
- R1: A receive byte tagged as an alignment frame is held pending. When the next non-alignment byte arrives, the alignment word takes the pending byte and the non-alignment word takes the new byte, both on the same clock edge. `rx_af_pulse` is high for exactly the one cycle after that edge.
- R2: A non-alignment byte that arrives with no alignment byte pending changes neither receive word and raises no pulse.
- R3: The receive words keep their values until the next complete alignment/non-alignment pair. An alignment byte on its own does not change them.
- R4: A transmit request for an alignment frame samples both host words and raises `tx_af_pulse` for one cycle. One cycle after any transmit request, `tx_ts0_valid` is high for one cycle. For an alignment frame, `tx_ts0_data` is then the host alignment word's bit 7 followed by 0011011 in bits 6..0, and host bits 6..0 are ignored.
- R5: A non-alignment transmit byte is built from the host non-alignment word sampled at the latest alignment request. Later host writes are not seen until the next alignment request. Bit 7 is Si, bit 6 is forced to 1, bit 5 is the alarm bit A, and bits 4..0 are Sa4..Sa8.
- R6: If `si_from_serial`, `crc4_en` or `ebit_auto_en` is 1, bit 7 of the transmitted byte equals `ext_si` in both frame types, replacing the host Si bit.
- R7: For each i, when `sa_src_en[i]` is 1, bit i of a non-alignment transmit byte equals `ext_sa[i]`. Bits whose enable is 0 keep the sampled host value.
- R8: `rx_af_flag` and `tx_af_flag` become 1 in the same cycle as their pulse and return to 0 one cycle after their acknowledge is sampled. A new event arriving in the same cycle as an acknowledge leaves the flag set.
- R9: While reset is active and just after it is released, both receive words, both flags, both pulses, `tx_ts0_valid` and `tx_ts0_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_ts0_valid | input | 1 | Receive timeslot-0 byte present |
| rx_ts0_align | input | 1 | 1 = byte is from an alignment frame |
| rx_ts0_data | input | 8 | Received timeslot-0 byte |
| rx_af_ack | input | 1 | Clears the receive sticky flag |
| host_tx_align | input | 8 | Host transmit alignment word (bit 7 = Si) |
| host_tx_nalign | input | 8 | Host transmit non-alignment word |
| tx_ts0_req | input | 1 | Framer requests a timeslot-0 byte |
| tx_ts0_align | input | 1 | 1 = request is for an alignment frame |
| si_from_serial | input | 1 | Si is taken from serial data |
| crc4_en | input | 1 | CRC-4 mode owns Si |
| ebit_auto_en | input | 1 | Automatic E-bit insertion owns Si |
| ext_si | input | 1 | Replacement Si value |
| sa_src_en | input | 5 | Per-bit Sa override enables (bit 4 = Sa4) |
| ext_sa | input | 5 | Replacement Sa values (bit 4 = Sa4) |
| tx_af_ack | input | 1 | Clears the transmit sticky flag |
| rx_align_word | output | 8 | Captured alignment timeslot 0 |
| rx_nalign_word | output | 8 | Captured non-alignment timeslot 0 |
| rx_af_pulse | output | 1 | Receive words just updated |
| rx_af_flag | output | 1 | Sticky receive event |
| tx_ts0_valid | output | 1 | Transmit byte ready |
| tx_ts0_data | output | 8 | Transmit timeslot-0 byte |
| tx_af_pulse | output | 1 | Host words just sampled |
| tx_af_flag | output | 1 | Sticky transmit event |

## Verification
The receive path is driven with a normal pair, with an orphan non-alignment byte, and with a lone alignment byte. Together these separate correct paired capture from capture of single bytes. The transmit path is first driven with no overrides. The host non-alignment word is then changed between alignment requests, which shows the per-pair sampling rather than a live pass-through. Each Si control is then raised on its own, and two complementary Sa enable masks are applied so that a swapped or shifted bit mapping is caught.

// File: rtl/e1s_pkg.sv
package e1s_pkg;
  localparam int TS_W   = 8;
  localparam int SA_N   = 5;
  localparam int SI_BIT = 7;
  localparam int FIX_BIT = 6;
  localparam int A_BIT  = 5;
  localparam logic [6:0] FAS_PAT = 7'b0011011;
endpackage

// File: rtl/e1s_rx_capture.sv
module e1s_rx_capture #(
  parameter int W = e1s_pkg::TS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_align,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] align_word,
  output logic [W-1:0] nalign_word,
  output logic         commit,
  output logic         pulse
);
  logic         pend_q, pend_d;
  logic [W-1:0] pdata_q, pdata_d;
  logic [W-1:0] align_q, align_d, nalign_q, nalign_d;
  logic         pulse_q;
  logic         take_align;

  always_comb begin
    take_align = in_valid & in_align;
    commit     = in_valid & ~in_align & pend_q;
    pend_d     = pend_q;
    pdata_d    = pdata_q;
    align_d    = align_q;
    nalign_d   = nalign_q;
    if (take_align) begin
      pend_d  = 1'b1;
      pdata_d = in_data;
    end else if (commit) begin
      pend_d   = 1'b0;
      align_d  = pdata_q;
      nalign_d = in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      pdata_q  <= '0;
      align_q  <= '0;
      nalign_q <= '0;
      pulse_q  <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      pdata_q  <= pdata_d;
      align_q  <= align_d;
      nalign_q <= nalign_d;
      pulse_q  <= commit;
    end
  end

  assign align_word  = align_q;
  assign nalign_word = nalign_q;
  assign pulse       = pulse_q;
endmodule

// File: rtl/e1s_tx_build.sv
module e1s_tx_build #(
  parameter int W  = e1s_pkg::TS_W,
  parameter int SN = e1s_pkg::SA_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  host_align,
  input  logic [W-1:0]  host_nalign,
  input  logic          req,
  input  logic          req_align,
  input  logic          si_ovr,
  input  logic          ext_si,
  input  logic [SN-1:0] sa_en,
  input  logic [SN-1:0] ext_sa,
  output logic          sample_evt,
  output logic          valid,
  output logic [W-1:0]  data,
  output logic          pulse
);
  import e1s_pkg::*;

  logic [W-1:0]  samp_q, samp_d;
  logic [W-1:0]  data_q, data_d;
  logic          valid_q, pulse_q;
  logic [W-1:0]  src;
  logic [SN-1:0] sa_mix;
  logic          si_bit;
  logic [W-1:0]  built;

  genvar gi;
  generate
    for (gi = 0; gi < SN; gi++) begin : g_sa
      assign sa_mix[gi] = sa_en[gi] ? ext_sa[gi] : src[gi];
    end
  endgenerate

  always_comb begin
    sample_evt = req & req_align;
    src        = sample_evt ? host_nalign : samp_q;
    samp_d     = src;
    si_bit     = si_ovr ? ext_si : (req_align ? host_align[SI_BIT] : src[SI_BIT]);
    if (req_align) begin
      built = {si_bit, FAS_PAT};
    end else begin
      built          = '0;
      built[SI_BIT]  = si_bit;
      built[FIX_BIT] = 1'b1;
      built[A_BIT]   = src[A_BIT];
      built[SN-1:0]  = sa_mix;
    end
    data_d = req ? built : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      samp_q  <= samp_d;
      data_q  <= data_d;
      valid_q <= req;
      pulse_q <= sample_evt;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;
  assign pulse = pulse_q;
endmodule

// File: rtl/e1s_sticky.sv
module e1s_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb flag_d = set | (flag_q & ~ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/e1s_ts0_access.sv
module e1s_ts0_access #(
  parameter int W  = e1s_pkg::TS_W,
  parameter int SN = e1s_pkg::SA_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_ts0_valid,
  input  logic          rx_ts0_align,
  input  logic [W-1:0]  rx_ts0_data,
  input  logic          rx_af_ack,
  input  logic [W-1:0]  host_tx_align,
  input  logic [W-1:0]  host_tx_nalign,
  input  logic          tx_ts0_req,
  input  logic          tx_ts0_align,
  input  logic          si_from_serial,
  input  logic          crc4_en,
  input  logic          ebit_auto_en,
  input  logic          ext_si,
  input  logic [SN-1:0] sa_src_en,
  input  logic [SN-1:0] ext_sa,
  input  logic          tx_af_ack,
  output logic [W-1:0]  rx_align_word,
  output logic [W-1:0]  rx_nalign_word,
  output logic          rx_af_pulse,
  output logic          rx_af_flag,
  output logic          tx_ts0_valid,
  output logic [W-1:0]  tx_ts0_data,
  output logic          tx_af_pulse,
  output logic          tx_af_flag
);
  logic rx_commit;
  logic tx_sample;
  logic si_ovr;

  assign si_ovr = si_from_serial | crc4_en | ebit_auto_en;

  e1s_rx_capture #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_ts0_valid), .in_align(rx_ts0_align), .in_data(rx_ts0_data),
    .align_word(rx_align_word), .nalign_word(rx_nalign_word),
    .commit(rx_commit), .pulse(rx_af_pulse)
  );

  e1s_tx_build #(.W(W), .SN(SN)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .host_align(host_tx_align), .host_nalign(host_tx_nalign),
    .req(tx_ts0_req), .req_align(tx_ts0_align),
    .si_ovr(si_ovr), .ext_si(ext_si),
    .sa_en(sa_src_en), .ext_sa(ext_sa),
    .sample_evt(tx_sample), .valid(tx_ts0_valid),
    .data(tx_ts0_data), .pulse(tx_af_pulse)
  );

  e1s_sticky u_rx_flag (
    .clk(clk), .rst_n(rst_n), .set(rx_commit), .ack(rx_af_ack), .flag(rx_af_flag)
  );

  e1s_sticky u_tx_flag (
    .clk(clk), .rst_n(rst_n), .set(tx_sample), .ack(tx_af_ack), .flag(tx_af_flag)
  );
endmodule

// File: rtl/e1s_ts0_access_chk.sv
module e1s_ts0_access_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_af_pulse,
  input logic       rx_af_flag,
  input logic [7:0] rx_align_word,
  input logic [7:0] rx_nalign_word,
  input logic       tx_ts0_req,
  input logic       tx_ts0_align,
  input logic       tx_ts0_valid,
  input logic [7:0] tx_ts0_data,
  input logic       tx_af_pulse,
  input logic       tx_af_flag,
  input logic       si_from_serial,
  input logic       crc4_en,
  input logic       ebit_auto_en,
  input logic       ext_si
);
  a_r1_rx_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_af_pulse |=> !rx_af_pulse);

  a_r3_rx_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_af_pulse |-> ($stable(rx_align_word) && $stable(rx_nalign_word)));

  a_r4_tx_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ts0_req |=> tx_ts0_valid);

  a_r4_fas_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ts0_valid && $past(tx_ts0_align)) |-> (tx_ts0_data[6:0] == 7'b0011011));

  a_r5_fixed_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ts0_valid && !$past(tx_ts0_align)) |-> tx_ts0_data[6]);

  a_r6_si_override: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ts0_valid && $past(si_from_serial || crc4_en || ebit_auto_en))
      |-> (tx_ts0_data[7] == $past(ext_si)));

  a_r8_rx_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rx_af_pulse |-> rx_af_flag);

  a_r8_tx_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    tx_af_pulse |-> tx_af_flag);
endmodule

bind e1s_ts0_access e1s_ts0_access_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .rx_af_pulse(rx_af_pulse), .rx_af_flag(rx_af_flag),
  .rx_align_word(rx_align_word), .rx_nalign_word(rx_nalign_word),
  .tx_ts0_req(tx_ts0_req), .tx_ts0_align(tx_ts0_align),
  .tx_ts0_valid(tx_ts0_valid), .tx_ts0_data(tx_ts0_data),
  .tx_af_pulse(tx_af_pulse), .tx_af_flag(tx_af_flag),
  .si_from_serial(si_from_serial), .crc4_en(crc4_en),
  .ebit_auto_en(ebit_auto_en), .ext_si(ext_si)
);

// File: tb/tb_e1s_ts0_access.sv
module tb_e1s_ts0_access;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       rx_ts0_valid, rx_ts0_align, rx_af_ack;
  logic [7:0] rx_ts0_data, host_tx_align, host_tx_nalign;
  logic       tx_ts0_req, tx_ts0_align, si_from_serial, crc4_en, ebit_auto_en, ext_si;
  logic [4:0] sa_src_en, ext_sa;
  logic       tx_af_ack;
  logic [7:0] rx_align_word, rx_nalign_word, tx_ts0_data;
  logic       rx_af_pulse, rx_af_flag, tx_ts0_valid, tx_af_pulse, tx_af_flag;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  e1s_ts0_access dut (.*);

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rx_send(input logic al, input logic [7:0] d);
    rx_ts0_valid = 1; rx_ts0_align = al; rx_ts0_data = d;
    step();
    rx_ts0_valid = 0;
  endtask

  task automatic tx_send(input logic al);
    tx_ts0_req = 1; tx_ts0_align = al;
    step();
    tx_ts0_req = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    rx_ts0_valid = 0; rx_ts0_align = 0; rx_ts0_data = 0; rx_af_ack = 0;
    host_tx_align = 0; host_tx_nalign = 0; tx_ts0_req = 0; tx_ts0_align = 0;
    si_from_serial = 0; crc4_en = 0; ebit_auto_en = 0; ext_si = 0;
    sa_src_en = 0; ext_sa = 0; tx_af_ack = 0;
    repeat (3) @(negedge clk);
    chk("R9 rx words in reset", rx_align_word | rx_nalign_word, 8'h00);
    rst_n = 1;
    step();
    chk("R9 rx align word", rx_align_word, 8'h00);
    chk("R9 rx nalign word", rx_nalign_word, 8'h00);
    chk("R9 flags/pulses/valid", {4'b0, rx_af_pulse, rx_af_flag, tx_af_pulse, tx_af_flag} | {7'b0, tx_ts0_valid}, 8'h00);
    chk("R9 tx data", tx_ts0_data, 8'h00);
  endtask

  task automatic t_rx_pair();
    rx_send(1, 8'h9B);
    chk("R1 align alone no update", rx_align_word, 8'h00);
    chk("R1 no pulse yet", {7'b0, rx_af_pulse}, 8'h00);
    rx_send(0, 8'h5F);
    chk("R1 pulse", {7'b0, rx_af_pulse}, 8'h01);
    chk("R1 align word", rx_align_word, 8'h9B);
    chk("R1 nalign word", rx_nalign_word, 8'h5F);
    chk("R8 rx flag with pulse", {7'b0, rx_af_flag}, 8'h01);
    step();
    chk("R1 pulse one cycle", {7'b0, rx_af_pulse}, 8'h00);
  endtask

  task automatic t_rx_orphan();
    rx_send(0, 8'h33);
    chk("R2 orphan no pulse", {7'b0, rx_af_pulse}, 8'h00);
    chk("R2 orphan align kept", rx_align_word, 8'h9B);
    chk("R2 orphan nalign kept", rx_nalign_word, 8'h5F);
  endtask

  task automatic t_rx_hold();
    repeat (4) step();
    rx_send(1, 8'h1B);
    step();
    chk("R3 held after lone align", rx_align_word, 8'h9B);
    chk("R3 nalign held", rx_nalign_word, 8'h5F);
    rx_send(0, 8'h40);
    chk("R3 new align", rx_align_word, 8'h1B);
    chk("R3 new nalign", rx_nalign_word, 8'h40);
  endtask

  task automatic t_rx_sticky();
    rx_af_ack = 1; step(); rx_af_ack = 0;
    chk("R8 rx flag cleared", {7'b0, rx_af_flag}, 8'h00);
    rx_send(1, 8'h9B);
    rx_af_ack = 1;
    rx_send(0, 8'h11);
    rx_af_ack = 0;
    chk("R8 set wins over ack", {7'b0, rx_af_flag}, 8'h01);
  endtask

  task automatic t_tx_basic();
    host_tx_align = 8'hC5; host_tx_nalign = 8'h35;
    tx_af_ack = 1;
    tx_send(1);
    tx_af_ack = 0;
    chk("R4 valid", {7'b0, tx_ts0_valid}, 8'h01);
    chk("R4 align byte", tx_ts0_data, 8'h9B);
    chk("R4 af pulse", {7'b0, tx_af_pulse}, 8'h01);
    chk("R8 tx flag set wins", {7'b0, tx_af_flag}, 8'h01);
    step();
    chk("R4 valid one cycle", {6'b0, tx_ts0_valid, tx_af_pulse}, 8'h00);
    tx_af_ack = 1; step(); tx_af_ack = 0;
    chk("R8 tx flag cleared", {7'b0, tx_af_flag}, 8'h00);
    tx_send(0);
    chk("R5 nalign byte", tx_ts0_data, 8'h75);
    chk("R4 no pulse on nalign", {7'b0, tx_af_pulse}, 8'h00);
  endtask

  task automatic t_tx_resample();
    host_tx_nalign = 8'hAA;
    tx_send(0);
    chk("R5 late write not seen", tx_ts0_data, 8'h75);
    host_tx_align = 8'h00;
    tx_send(1);
    chk("R4 align Si 0", tx_ts0_data, 8'h1B);
    tx_send(0);
    chk("R5 new sample used", tx_ts0_data, 8'hEA);
  endtask

  task automatic t_si_override();
    host_tx_align = 8'h80; host_tx_nalign = 8'h80; ext_si = 0;
    for (int k = 0; k < 3; k++) begin
      si_from_serial = (k == 0); crc4_en = (k == 1); ebit_auto_en = (k == 2);
      tx_send(1);
      chk("R6 align Si replaced", tx_ts0_data, 8'h1B);
      tx_send(0);
      chk("R6 nalign Si replaced", tx_ts0_data, 8'h40);
    end
    si_from_serial = 0; crc4_en = 0; ebit_auto_en = 0;
    tx_send(0);
    chk("R6 no override host Si", tx_ts0_data, 8'hC0);
  endtask

  task automatic t_sa_override();
    host_tx_nalign = 8'h00; sa_src_en = 5'b10010; ext_sa = 5'b11111;
    tx_send(1);
    tx_send(0);
    chk("R7 mask 10010 ones", tx_ts0_data, 8'h52);
    host_tx_nalign = 8'h1F; sa_src_en = 5'b00101; ext_sa = 5'b00000;
    tx_send(1);
    tx_send(0);
    chk("R7 mask 00101 zeros", tx_ts0_data, 8'h5A);
    sa_src_en = 0;
  endtask

  initial begin
    t_reset();
    t_rx_pair();
    t_rx_orphan();
    t_rx_hold();
    t_rx_sticky();
    t_tx_basic();
    t_tx_resample();
    t_si_override();
    t_sa_override();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule